// File: doc/BRIEF.md
# MDIO Management Frame Shift Register

This block holds one 32-bit management word and plays it out as a PHY management frame on a two-wire MDIO bus. When a host writes the word while the block is idle, the operation starts. The word then rotates once through a circular shift register. On every period of the divided management clock, the top bit drives the data line and the bottom bit takes the value sampled from the line. After 32 periods every bit is back in its original position, a done flag sets and a one-cycle interrupt fires.

The frame layout is the usual one: start code in bits [31:30], opcode in [29:28], PHY and register addresses below that, turnaround in [17:16] and data in [15:0]. Both start codes are accepted. The value 0110 in [31:28] is a clause 22 read and 0011 is a clause 45 read. Bit 29 set marks a read frame. For a read frame the block lets go of the line from the turnaround onward, so the PHY's reply is shifted into the low 18 bits. Write and address frames loop their own bits back and finish unchanged. A host may read the register at any time and see the shift in progress.

The management clock runs at the system clock divided by `DIV_RATIO`, which must be even and at least 4. It is high for the first half of each period. The data line changes one system clock after each falling edge.

Top module: `mdio_shift_reg`

## Requirements
- R1: After reset, `done`, `irq`, `mdc` and `mdio_oe` are 0 and `rd_data` is 0.
- R2: A write (`wr_en` high) while idle loads `wr_data`, clears `done` and starts an operation. `rd_data` shows the written value and `mdio_o` shows its bit 31 on the clock after the write.
- R3: During an operation `mdc` makes exactly 32 periods. Each period is DIV_RATIO/2 clocks high followed by DIV_RATIO/2 clocks low. The first high phase begins DIV_RATIO/2-1 clocks after the load edge.
- R4: `mdio_o` only changes on the clock edge one system clock after a falling edge of `mdc`. It never changes while `mdc` is high.
- R5: After j shifts (j = 0..31), `rd_data` equals the loaded word rotated left by j bit positions, with the line sampled back in at bit 0.
- R6: A frame with bit 29 = 0 (write or address) keeps `mdio_oe` high for all 32 periods and ends with `rd_data` equal to the written word.
- R7: A frame with bit 29 = 1 (clause 22 read 0110 or clause 45 read 0011 in [31:28]) drives `mdio_oe` high for periods 0..13 and low for periods 14..31. It ends with bits [31:18] unchanged and bits [17:0] equal to the line values the PHY drove in periods 14..31, most significant first.
- R8: `done` sets on the clock edge 32*DIV_RATIO clocks after the load edge. `irq` is high for exactly that one cycle.
- R9: A write that arrives while an operation is in progress is ignored. It changes neither the register contents nor the completion time.
- R10: `done` stays set until the next accepted write. While idle, `mdc` and `mdio_oe` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 32 | Management word to load |
| rd_data | output | 32 | Live shift register contents |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Sampled data line |
| done | output | 1 | Operation complete flag |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The bench models the PHY. While the block drives the line it echoes `mdio_o` back into `mdio_i`, and once the line is released it returns turnaround and data bits. If the output enable were released one period late, the PHY's first bit would be lost and the recovered read data would be shifted by one. The bench reads the register in the middle of an operation and compares it with the expected rotation, which exposes a design that shifts in the wrong direction or drops the sampled bit. It also times data line changes against the `mdc` falling edges, which catches a shift on the wrong edge. A write issued mid-operation catches a design that reloads and restarts, because the final word and the completion time would then be wrong. Completion is checked to the exact clock, with a single-cycle interrupt, so an off-by-one bit count shows up.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_W = 32;
  localparam int SLOT_W  = $clog2(FRAME_W);
  // opcode bit that marks a read frame in both clause encodings
  localparam int RD_OP_BIT = 29;
  // first period in which a read frame releases the line (turnaround)
  localparam int TA_SLOT = 14;
  typedef logic [FRAME_W-1:0] frame_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_RATIO = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic mdc,
  output logic sample_tick,
  output logic shift_tick
);
  localparam int HALF  = DIV_RATIO / 2;
  localparam int CNT_W = $clog2(DIV_RATIO);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  // phase 0..HALF-1 is mdc high, HALF..DIV_RATIO-1 is mdc low
  always_comb begin
    cnt_d = cnt_q;
    if (start) begin
      cnt_d = CNT_W'(HALF + 1);
    end else if (run) begin
      if (cnt_q == CNT_W'(DIV_RATIO - 1)) cnt_d = '0;
      else                                 cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign mdc         = run && (cnt_q < CNT_W'(HALF));
  assign sample_tick = run && (cnt_q == CNT_W'(DIV_RATIO - 1));
  assign shift_tick  = run && (cnt_q == CNT_W'(HALF));
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic is_read,
  input  logic shift_tick,
  output logic busy,
  output logic drive_en,
  output logic done,
  output logic irq
);
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic busy_q, busy_d, rd_q, rd_d, done_q, done_d, irq_q, irq_d;
  logic last;

  assign last = shift_tick && (slot_q == SLOT_W'(FRAME_W - 1));

  always_comb begin
    slot_d = slot_q;
    busy_d = busy_q;
    rd_d   = rd_q;
    done_d = done_q;
    irq_d  = 1'b0;
    if (start) begin
      slot_d = '0;
      busy_d = 1'b1;
      rd_d   = is_read;
      done_d = 1'b0;
    end else if (shift_tick) begin
      slot_d = slot_q + SLOT_W'(1);
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        irq_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      slot_q <= slot_d;
      busy_q <= busy_d;
      rd_q   <= rd_d;
      done_q <= done_d;
      irq_q  <= irq_d;
    end
  end

  assign busy     = busy_q;
  assign drive_en = busy_q && !(rd_q && (slot_q >= SLOT_W'(TA_SLOT)));
  assign done     = done_q;
  assign irq      = irq_q;
endmodule

// File: rtl/mdio_shift_core.sv
module mdio_shift_core
  import mdio_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  frame_t load_val,
  input  logic   sample_tick,
  input  logic   shift_tick,
  input  logic   line_in,
  output frame_t sr,
  output logic   bit_out
);
  frame_t sr_q, sr_d;
  logic   samp_q, samp_d;

  always_comb begin
    samp_d = samp_q;
    if (sample_tick) samp_d = line_in;
    sr_d = sr_q;
    if (load)            sr_d = load_val;
    else if (shift_tick) sr_d = {sr_q[FRAME_W-2:0], samp_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      samp_q <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      samp_q <= samp_d;
    end
  end

  assign sr      = sr_q;
  assign bit_out = sr_q[FRAME_W-1];
endmodule

// File: rtl/mdio_shift_reg.sv
module mdio_shift_reg
  import mdio_pkg::*;
#(
  parameter int DIV_RATIO = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i,
  output logic        done,
  output logic        irq
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  logic       busy, start, sample_tick, shift_tick;
  frame_t     sr;

  // assert asynchronously, release on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign start = wr_en && !busy;

  mdio_mdc_gen #(.DIV_RATIO(DIV_RATIO)) u_mdc (
    .clk(clk), .rst_n(rst_core_n), .start(start), .run(busy),
    .mdc(mdc), .sample_tick(sample_tick), .shift_tick(shift_tick)
  );

  mdio_frame_seq u_seq (
    .clk(clk), .rst_n(rst_core_n), .start(start),
    .is_read(wr_data[RD_OP_BIT]), .shift_tick(shift_tick),
    .busy(busy), .drive_en(mdio_oe), .done(done), .irq(irq)
  );

  mdio_shift_core u_core (
    .clk(clk), .rst_n(rst_core_n), .load(start), .load_val(wr_data),
    .sample_tick(sample_tick), .shift_tick(shift_tick), .line_in(mdio_i),
    .sr(sr), .bit_out(mdio_o)
  );

  assign rd_data = sr;
endmodule

// File: rtl/mdio_shift_reg_chk.sv
module mdio_shift_reg_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic busy,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe,
  input logic done,
  input logic irq
);
  // R8: interrupt only together with the done flag
  a_r8_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);
  // R8: interrupt lasts one cycle
  a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R8: done never rises without the interrupt
  a_r8_done_rise_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> irq);
  // R4: data line holds while mdc stays high
  a_r4_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdio_o));
  // R10: quiet bus while idle and complete
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mdio_oe && !mdc));
  // R2: accepted write starts an operation and clears done
  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy) |=> (busy && !done));
endmodule

bind mdio_shift_reg mdio_shift_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy), .mdc(mdc),
  .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(done), .irq(irq)
);

// File: tb/mdio_shift_reg_tb.sv
module mdio_shift_reg_tb_top;
  localparam int DIV  = 8;
  localparam int HALF = DIV / 2;
  localparam int OPC  = 32 * DIV;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        mdc, mdio_o, mdio_oe, done, irq;
  logic        phy_line;
  logic        mdio_i;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign mdio_i = mdio_oe ? mdio_o : phy_line;

  mdio_shift_reg #(.DIV_RATIO(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i), .done(done), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rotl(input logic [31:0] v, input int j);
    if (j == 0) return v;
    return (v << j) | (v >> (32 - j));
  endfunction

  function automatic logic phy_bit(input int slot, input logic [15:0] d);
    if (slot == 14) return 1'b1;
    if (slot == 15) return 1'b0;
    if (slot >= 16 && slot < 32) return d[31 - slot];
    return 1'b1;
  endfunction

  // one full operation; ign_at < 0 disables the mid-run write
  task automatic run_op(input logic [31:0] frame, input logic [15:0] phyd,
                        input bit live, input int ign_at);
    bit is_rd = frame[29];
    logic [31:0] exp_end;
    int slot = 0;
    int hi_cnt = 0;
    int rises = 0;
    int oe_bad = 0;
    int chg_bad = 0;
    logic m1, m2, prev_o;
    exp_end = is_rd ? {frame[31:18], 2'b10, phyd} : frame;
    phy_line = phy_bit(0, phyd);
    @(negedge clk);
    wr_en = 1'b1; wr_data = frame;
    @(posedge clk); #1;
    wr_en = 1'b0;
    chk(done == 1'b0, "R2/R10 done cleared by write", {31'b0, done}, 32'h0);
    chk(rd_data == frame, "R2 loaded value readable", rd_data, frame);
    chk(mdio_o == frame[31], "R2 msb on line", {31'b0, mdio_o}, {31'b0, frame[31]});
    m1 = mdc; m2 = 1'b0; prev_o = mdio_o;
    for (int n = 1; n <= OPC + 1; n++) begin
      @(posedge clk); #1;
      wr_en = 1'b0;
      if (n == ign_at) begin wr_en = 1'b1; wr_data = ~frame; end
      if (n <= OPC) begin
        if (mdc) hi_cnt++;
        if (mdc && !m1) rises++;
        if (n == HALF - 1 && !mdc) chk(0, "R3 first rise time", 0, 1);
        if (m1 && !mdc) begin slot++; phy_line = phy_bit(slot, phyd); end
        if (mdc && (mdio_oe !== !(is_rd && slot >= 14))) oe_bad++;
        if ((mdio_o !== prev_o) && !(m2 == 1'b1 && m1 == 1'b0)) chg_bad++;
      end
      if (live && (n == 5 * DIV + 2))
        chk(rd_data == rotl(frame, 5), "R5 live rotate 5", rd_data, rotl(frame, 5));
      if (live && (n == 17 * DIV + 2))
        chk(rd_data == rotl(frame, 17), "R5 live rotate 17", rd_data, rotl(frame, 17));
      if (n == OPC - 1)
        chk(done == 1'b0, "R8 done not early", {31'b0, done}, 32'h0);
      if (n == OPC) begin
        chk(done && irq, "R8 done and irq at completion", {30'b0, done, irq}, 32'h3);
        chk(rd_data == exp_end, is_rd ? "R7 read result" : "R6 write restored",
            rd_data, exp_end);
      end
      if (n == OPC + 1) begin
        chk(!irq && done, "R8/R10 irq single and done held", {30'b0, done, irq}, 32'h2);
        chk(!mdc && !mdio_oe, "R10 idle bus quiet", {30'b0, mdc, mdio_oe}, 32'h0);
      end
      m2 = m1; m1 = mdc; prev_o = mdio_o;
    end
    wr_en = 1'b0;
    chk(rises == 32, "R3 mdc period count", rises, 32);
    chk(hi_cnt == 32 * HALF, "R3 mdc high time", hi_cnt, 32 * HALF);
    chk(oe_bad == 0, is_rd ? "R7 output enable pattern" : "R6 output enable held",
        oe_bad, 0);
    chk(chg_bad == 0, "R4 line changes after falling edge", chg_bad, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; phy_line = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk({done, irq, mdc, mdio_oe} == 4'b0, "R1 reset outputs",
        {28'b0, done, irq, mdc, mdio_oe}, 32'h0);
    chk(rd_data == 32'h0, "R1 reset contents", rd_data, 32'h0);
  endtask

  task automatic t_write_c22();
    run_op({2'b01, 2'b01, 5'h03, 5'h04, 2'b10, 16'hA5C3}, 16'h0, 1'b1, -1);
  endtask

  task automatic t_read_c22();
    run_op({2'b01, 2'b10, 5'h01, 5'h02, 2'b11, 16'h0000}, 16'h3C96, 1'b0, -1);
  endtask

  task automatic t_read_c45();
    run_op({4'b0011, 5'h1F, 5'h05, 2'b11, 16'hFFFF}, 16'h0F01, 1'b0, -1);
  endtask

  task automatic t_addr_c45();
    run_op({4'b0000, 5'h0A, 5'h03, 2'b10, 16'h1234}, 16'hFFFF, 1'b0, -1);
  endtask

  task automatic t_ignore_busy();
    // R9: mid-run write must not alter contents or completion time
    run_op({2'b01, 2'b01, 5'h15, 5'h0B, 2'b10, 16'h5AF0}, 16'h0, 1'b1, 40);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_write_c22();
    t_read_c22();
    t_read_c45();
    t_addr_c45();
    t_ignore_busy();
    repeat (3) @(posedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule